// File: doc/BRIEF.md
# Variable-Pulse-Width Passive Gap Classifier

This block watches a single-wire bus that uses variable pulse widths and times every passive phase. It measures how long the line stays passive in units of a 1 µs tick, which an internal prescaler derives from the system clock. When the line returns to active, the block reports what that gap meant. A gap can be too short to be valid, a logic zero (nominally 64 µs), a logic one (nominally 128 µs), or an end-of-data marker (nominally 200 µs). Any gap that lands in no window is reported as invalid.

The bus level enters through a two-flop synchronizer, and both edges are detected on the synchronized copy. A result appears as a one-cycle valid strobe with a 2-bit class code. If the line stays passive past the upper limit of the end-of-data window, the block raises a single idle strobe at once. It then stops timing and ignores the next return to active. Each window's lower and upper limit is a parameter. A limit value belongs to the window above it, so each window is half-open: [min, max).

The block serves a receiver front end. A later stage turns the class codes into bits and frames.

Top module: `vpw_passive_classifier`

## Requirements
- R1: A return to active on `bus_i` (1 = active, 0 = passive) raises `sym_valid_o` after the third rising clock edge that follows the change, and not earlier. Timing of a gap starts at the active-to-passive edge seen through the same two-flop path.
- R2: A gap shorter than `ZERO_MIN` ticks (default 34) is reported with class code 2'b00 (invalid).
- R3: A gap of at least `ZERO_MIN` and below `ZERO_MAX` ticks (default 34..95) is reported with class code 2'b01 (logic zero).
- R4: A gap of at least `ONE_MIN` and below `ONE_MAX` ticks (default 96..162) is reported with class code 2'b10 (logic one).
- R5: A gap of at least `EOD_MIN` and below `EOD_MAX` ticks (default 163..238) is reported with class code 2'b11 (end-of-data).
- R6: A gap equal to a window's limit belongs to the window above it: 33 gives invalid, 34 gives zero, 96 gives one and 163 gives end-of-data.
- R7: If the line stays passive until the gap count reaches `EOD_MAX`, `idle_o` pulses for exactly one cycle without waiting for an edge. The return to active that follows produces no `sym_valid_o`.
- R8: `sym_valid_o` lasts one cycle, and `sym_class_o` keeps its value in the cycle after the strobe.
- R9: After reset, `sym_valid_o` and `idle_o` are 0 and `sym_class_o` is 2'b00.
- R10: A return to active that no timed passive phase precedes produces no strobe. This covers the first one after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_i | input | 1 | Asynchronous bus level, 1 = active, 0 = passive |
| sym_valid_o | output | 1 | One-cycle strobe: a gap has been classified |
| sym_class_o | output | 2 | Class code: 00 invalid, 01 zero, 10 one, 11 end-of-data |
| idle_o | output | 1 | One-cycle strobe: passive phase ran past the end-of-data window |

## Verification
A result is due on the third rising edge after the bench drives the line active: two edges go to the synchronizer and one to the result register. Each scenario task drives the bus on a falling edge, checks on the falling edges after the second and after the third rising edge that the strobe is low and then high, and checks the held code one cycle later. Each gap is held for N·CLKS_PER_TICK + 2 cycles, so the return edge falls halfway between tick boundaries and the expected count is exactly N. The idle strobe is due one cycle after the count reaches `EOD_MAX`. A negedge monitor counts idle and valid pulses across the whole long-passive phase, including the return to active that follows it.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [1:0] {
        CLS_INVALID = 2'b00,
        CLS_ZERO    = 2'b01,
        CLS_ONE     = 2'b10,
        CLS_EOD     = 2'b11
    } vpw_class_e;

    typedef struct packed {
        logic       valid;
        vpw_class_e cls;
    } vpw_result_t;

    typedef struct packed {
        logic rise;  // passive -> active
        logic fall;  // active -> passive
    } vpw_edges_t;

    // Half-open windows [min, max): a limit value belongs to the window above.
    function automatic vpw_class_e vpw_classify(
        input int unsigned gap,
        input int unsigned z_min, input int unsigned z_max,
        input int unsigned o_min, input int unsigned o_max,
        input int unsigned e_min, input int unsigned e_max
    );
        vpw_class_e c;
        c = CLS_INVALID;
        if (gap >= z_min && gap < z_max)      c = CLS_ZERO;
        else if (gap >= o_min && gap < o_max) c = CLS_ONE;
        else if (gap >= e_min && gap < e_max) c = CLS_EOD;
        return c;
    endfunction

endpackage

// File: rtl/vpw_bus_sync.sv
module vpw_bus_sync
    import vpw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       bus_i,
    output vpw_edges_t edges_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= bus_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        edges_o.rise = sync_q & ~prev_q;
        edges_o.fall = ~sync_q & prev_q;
    end

    AST_RISE_TWO_FLOPS: assert property (@(posedge clk_i) disable iff (rst_i)
        edges_o.rise |-> ($past(bus_i, 2) == 1'b1)); // R1

    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(edges_o.rise && edges_o.fall)); // R1

endmodule

// File: rtl/vpw_gap_timer.sv
module vpw_gap_timer
    import vpw_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 100,
    parameter int unsigned LIMIT         = 239,
    parameter int unsigned CNT_W         = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  vpw_edges_t       edges_i,
    output logic [CNT_W-1:0] gap_o,
    output logic             done_o,
    output logic             idle_o
);
    localparam int unsigned DIV_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_TICK - 1);
    localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    logic             running_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             idle_q;
    logic             tick;

    assign tick = running_q && (div_q == DIV_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            running_q <= 1'b0;
            div_q     <= '0;
            cnt_q     <= '0;
            idle_q    <= 1'b0;
        end else begin
            idle_q <= 1'b0;
            if (edges_i.fall) begin
                running_q <= 1'b1;
                div_q     <= '0;
                cnt_q     <= '0;
            end else if (edges_i.rise) begin
                running_q <= 1'b0;
            end else if (running_q) begin
                if (cnt_q >= CNT_LIM) begin
                    running_q <= 1'b0;
                    idle_q    <= 1'b1;
                end else begin
                    div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
                    if (tick && cnt_q != CNT_SAT)
                        cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign gap_o  = cnt_q;
    assign done_o = running_q && edges_i.rise;
    assign idle_o = idle_q;

    AST_GAP_BOUNDED: assert property (@(posedge clk_i) disable iff (rst_i)
        running_q |-> (cnt_q <= CNT_LIM)); // R7

    AST_IDLE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        idle_q |=> !idle_q); // R7

    AST_IDLE_STOPS: assert property (@(posedge clk_i) disable iff (rst_i)
        idle_q |-> !running_q); // R7

endmodule

// File: rtl/vpw_window_judge.sv
module vpw_window_judge
    import vpw_pkg::*;
#(
    parameter int unsigned ZERO_MIN = 34,
    parameter int unsigned ZERO_MAX = 96,
    parameter int unsigned ONE_MIN  = 96,
    parameter int unsigned ONE_MAX  = 163,
    parameter int unsigned EOD_MIN  = 163,
    parameter int unsigned EOD_MAX  = 239,
    parameter int unsigned CNT_W    = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] gap_i,
    input  logic             done_i,
    output vpw_result_t      res_o
);
    vpw_result_t res_q;
    vpw_class_e  cls_now;

    always_comb begin
        cls_now = vpw_classify(32'(gap_i), ZERO_MIN, ZERO_MAX,
                               ONE_MIN, ONE_MAX, EOD_MIN, EOD_MAX);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q.valid <= 1'b0;
            res_q.cls   <= CLS_INVALID;
        end else begin
            res_q.valid <= done_i;
            if (done_i) res_q.cls <= cls_now;
        end
    end

    assign res_o = res_q;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        res_q.valid |=> !res_q.valid); // R8

    AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        res_q.valid |=> $stable(res_q.cls)); // R8

    AST_SHORT_IS_INVALID: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_i && 32'(gap_i) < ZERO_MIN) |=> (res_q.cls == CLS_INVALID)); // R2

endmodule

// File: rtl/vpw_passive_classifier.sv
module vpw_passive_classifier
    import vpw_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 100,
    parameter int unsigned ZERO_MIN      = 34,
    parameter int unsigned ZERO_MAX      = 96,
    parameter int unsigned ONE_MIN       = 96,
    parameter int unsigned ONE_MAX       = 163,
    parameter int unsigned EOD_MIN       = 163,
    parameter int unsigned EOD_MAX       = 239
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       bus_i,
    output logic       sym_valid_o,
    output logic [1:0] sym_class_o,
    output logic       idle_o
);
    localparam int unsigned CNT_W = $clog2(EOD_MAX + 1) + 1;

    vpw_edges_t       edges;
    logic [CNT_W-1:0] gap;
    logic             done;
    logic             idle;
    vpw_result_t      res;

    vpw_bus_sync u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .bus_i  (bus_i),
        .edges_o(edges)
    );

    vpw_gap_timer #(
        .CLKS_PER_TICK(CLKS_PER_TICK),
        .LIMIT        (EOD_MAX),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .edges_i(edges),
        .gap_o  (gap),
        .done_o (done),
        .idle_o (idle)
    );

    vpw_window_judge #(
        .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
        .ONE_MIN (ONE_MIN),  .ONE_MAX (ONE_MAX),
        .EOD_MIN (EOD_MIN),  .EOD_MAX (EOD_MAX),
        .CNT_W   (CNT_W)
    ) u_judge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .gap_i (gap),
        .done_i(done),
        .res_o (res)
    );

    assign sym_valid_o = res.valid;
    assign sym_class_o = res.cls;
    assign idle_o      = idle;

    AST_NO_IDLE_WITH_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sym_valid_o && idle_o)); // R10

    AST_NO_VALID_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        idle_o |=> !sym_valid_o); // R7

endmodule

// File: tb/sim_vpw_passive_classifier.sv
module sim_vpw_passive_classifier;
    localparam int DIV = 4;
    localparam int EMAX = 239;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus = 1'b0;
    logic sym_valid;
    logic [1:0] sym_class;
    logic idle;

    int checks = 0;
    int errors = 0;
    int idle_seen = 0;
    int valid_seen = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    vpw_passive_classifier #(.CLKS_PER_TICK(DIV)) u0 (
        .clk_i(clk), .rst_i(rst), .bus_i(bus),
        .sym_valid_o(sym_valid), .sym_class_o(sym_class), .idle_o(idle)
    );

    always @(negedge clk) begin
        if (idle) idle_seen++;
        if (sym_valid) valid_seen++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Active phase, then a passive gap of n ticks, then return to active.
    task automatic send_gap(input int n, input int exp_cls, input string req);
        @(negedge clk); bus = 1'b1;
        wait_negs(16);
        bus = 1'b0;
        wait_negs(n * DIV + 2);
        bus = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check({req, "/R1 early"}, int'(sym_valid), 0);
        @(posedge clk); @(negedge clk);
        check({req, "/R1 strobe"}, int'(sym_valid), 1);
        check(req, int'(sym_class), exp_cls);
        @(posedge clk); @(negedge clk);
        check({req, "/R8 pulse"}, int'(sym_valid), 0);
        check({req, "/R8 hold"}, int'(sym_class), exp_cls);
    endtask

    task automatic test_reset();
        check("R9 valid", int'(sym_valid), 0);
        check("R9 class", int'(sym_class), 0);
        check("R9 idle", int'(idle), 0);
    endtask

    task automatic test_first_rise();
        int v0;
        v0 = valid_seen;
        @(negedge clk); bus = 1'b1;
        wait_negs(10);
        check("R10 no strobe", valid_seen - v0, 0);
    endtask

    task automatic test_idle();
        int v0, i0;
        v0 = valid_seen; i0 = idle_seen;
        @(negedge clk); bus = 1'b1;
        wait_negs(16);
        bus = 1'b0;
        wait_negs((EMAX + 30) * DIV);
        check("R7 one idle", idle_seen - i0, 1);
        bus = 1'b1;
        wait_negs(10);
        check("R7 no valid after idle", valid_seen - v0, 0);
        check("R7 idle once total", idle_seen - i0, 1);
    endtask

    initial begin
        wait_negs(4);
        test_reset();
        rst = 1'b0;
        test_first_rise();
        send_gap(10, 0, "R2 short");
        send_gap(64, 1, "R3 zero");
        send_gap(128, 2, "R4 one");
        send_gap(200, 3, "R5 eod");
        send_gap(33, 0, "R6 below zero");
        send_gap(34, 1, "R6 zero floor");
        send_gap(96, 2, "R6 one floor");
        send_gap(163, 3, "R6 eod floor");
        send_gap(238, 3, "R5 eod top");
        test_idle();
        send_gap(70, 1, "R3 after idle");
        done_flag = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done_flag; c++) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule